// File: doc/BRIEF.md
# Byte-wide Convolutional Interleaver

This block spreads the bytes of 204-byte coded packets over time so that a burst of channel errors is broken up into short, scattered errors after deinterleaving. Each accepted byte goes to one of twelve branches. The number of the branch sets how long the byte is held. Branch 0 passes its byte straight on. Every higher branch is a delay line that is 17 positions longer than the one below it. A commutator steps through the branches one byte at a time. A packet-start marker pulls the commutator back to branch 0, so the sync byte at the head of each packet always takes the undelayed path.

All delay lines share a single RAM that is split into twelve circular regions, so block RAM can be inferred. Until every delay line has been filled with real data, some output bytes carry contents left from reset. A noise flag goes with each output byte and stays high through that fill period. Reset and flush both restart the rotation and the fill tracking.

Top module: `byte_conv_interleaver`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_noise` is 1, and the first accepted byte is routed to branch 0.
- R2: The byte that is accepted on the k-th visit to branch j (j from 1 to 11) leaves the block on the (k + 17·j)-th visit to branch j.
- R3: Branch 0 adds no storage delay. A byte routed to branch 0 appears on `out_data` with the same two-cycle latency as every other output.
- R4: The commutator moves on only for cycles with `in_valid` = 1. Idle cycles change neither the rotation nor the output order.
- R5: A byte accepted with `in_sop` = 1 always goes to branch 0, whatever the position of the commutator. The byte after it goes to branch 1.
- R6: Without a marker, the commutator steps from branch 11 back to branch 0, so a stream of 204-byte packets stays aligned to its sync bytes.
- R7: `out_noise` is 1 for the outputs of the first 2244 (11·17·12) accepted bytes and 0 for every byte after them.
- R8: A one-cycle `flush` pulse clears the block in the same way as reset: `out_valid` is 0, `out_noise` is 1, the next byte goes to branch 0, and the 2244-byte fill count starts again.
- R9: Each accepted byte produces exactly one output with `out_valid` = 1, two clock cycles after it was accepted. No output appears without an accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Synchronous clear of rotation and fill state, active high |
| in_valid | input | 1 | Input byte qualifier |
| in_sop | input | 1 | Marks the first (sync) byte of a packet |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte qualifier |
| out_data | output | 8 | Interleaved byte |
| out_noise | output | 1 | High while the output may hold reset-fill contents |

## Verification
The first stimulus is a continuous run of marked 204-byte packets. It shows whether every branch delays by exactly its own multiple of 17 and whether the noise flag falls at byte 2244 and not one byte earlier or later. The same packets are then sent with idle gaps in them, which tells a commutator that counts valid bytes apart from one that counts cycles. Unmarked packets show whether the commutator wraps from 11 to 0 by itself. A marker placed part of the way through a packet shows the forced return to branch 0. A flush in the middle of the stream, followed by a full refill, checks that the rotation and the fill count restart together.

// File: rtl/cvi_pkg.sv
package cvi_pkg;
  // First RAM word of the circular region that belongs to branch j
  function automatic int region_base(input int j, input int step);
    return (step * j * (j - 1)) / 2;
  endfunction
endpackage

// File: rtl/cvi_commutator.sv
module cvi_commutator #(
  parameter int BRANCHES = 12,
  parameter int STEP     = 17,
  localparam int BW      = $clog2(BRANCHES),
  localparam int FILL    = (BRANCHES - 1) * STEP * BRANCHES,
  localparam int CW      = $clog2(FILL + 1)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          in_valid,
  input  logic          in_sop,
  output logic [BW-1:0] branch,
  output logic          filling
);
  logic [BW-1:0] ptr;
  logic [CW-1:0] cnt;
  logic          fill_done;

  assign branch  = in_sop ? '0 : ptr;
  assign filling = !fill_done;

  always_ff @(posedge clk) begin
    if (clr) begin
      ptr       <= '0;
      cnt       <= '0;
      fill_done <= 1'b0;
    end else if (in_valid) begin
      ptr <= (branch == BW'(BRANCHES - 1)) ? '0 : branch + 1'b1;
      if (!fill_done) begin
        cnt       <= cnt + 1'b1;
        fill_done <= (cnt == CW'(FILL - 1));
      end
    end
  end

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (clr)
    !in_valid |=> $stable(ptr));
  // R5
  sop_realign_chk: assert property (@(posedge clk) disable iff (clr)
    in_valid && in_sop |=> ptr == BW'(1));
  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (clr)
    in_valid && !in_sop && ptr == BW'(BRANCHES - 1) |=> ptr == '0);
  // R7
  fill_hold_chk: assert property (@(posedge clk) disable iff (clr)
    fill_done |=> fill_done);
endmodule

// File: rtl/cvi_addr_gen.sv
module cvi_addr_gen #(
  parameter int BRANCHES = 12,
  parameter int STEP     = 17,
  localparam int BW      = $clog2(BRANCHES),
  localparam int TOTAL   = STEP * BRANCHES * (BRANCHES - 1) / 2,
  localparam int AW      = $clog2(TOTAL),
  localparam int PW      = $clog2((BRANCHES - 1) * STEP)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          advance,
  input  logic [BW-1:0] branch,
  output logic [AW-1:0] addr
);
  logic [PW-1:0] ptr [1:BRANCHES-1];

  for (genvar j = 1; j < BRANCHES; j++) begin : g_branch
    localparam int DEPTH = j * STEP;
    always_ff @(posedge clk) begin
      if (clr)
        ptr[j] <= '0;
      else if (advance && branch == BW'(j))
        ptr[j] <= (ptr[j] == PW'(DEPTH - 1)) ? '0 : ptr[j] + 1'b1;
    end

    // R2
    ptr_range_chk: assert property (@(posedge clk) disable iff (clr)
      {1'b0, ptr[j]} < (PW + 1)'(DEPTH));
  end

  always_comb begin
    addr = '0;
    for (int j = 1; j < BRANCHES; j++)
      if (branch == BW'(j))
        addr = AW'(cvi_pkg::region_base(j, STEP)) + AW'(ptr[j]);
  end
endmodule

// File: rtl/cvi_ram.sv
module cvi_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 1122,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // read-first: the old word leaves as the new word lands
  always_ff @(posedge clk) begin
    if (en) begin
      rdata     <= mem[addr];
      mem[addr] <= wdata;
    end
  end
endmodule

// File: rtl/byte_conv_interleaver.sv
module byte_conv_interleaver #(
  parameter int DW       = 8,
  parameter int BRANCHES = 12,
  parameter int STEP     = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_noise
);
  localparam int BW    = $clog2(BRANCHES);
  localparam int TOTAL = STEP * BRANCHES * (BRANCHES - 1) / 2;
  localparam int AW    = $clog2(TOTAL);

  logic          clr;
  logic [BW-1:0] branch;
  logic          filling;
  logic [AW-1:0] addr;
  logic [DW-1:0] rd_data;
  logic          s1_valid, s1_bypass, s1_noise;
  logic [DW-1:0] s1_data;

  assign clr = rst || flush;

  cvi_commutator #(.BRANCHES(BRANCHES), .STEP(STEP)) comm_i (
    .clk(clk), .clr(clr), .in_valid(in_valid), .in_sop(in_sop),
    .branch(branch), .filling(filling));

  cvi_addr_gen #(.BRANCHES(BRANCHES), .STEP(STEP)) agen_i (
    .clk(clk), .clr(clr), .advance(in_valid), .branch(branch), .addr(addr));

  cvi_ram #(.DW(DW), .DEPTH(TOTAL)) ram_i (
    .clk(clk), .en(in_valid && branch != '0), .addr(addr),
    .wdata(in_data), .rdata(rd_data));

  always_ff @(posedge clk) begin
    if (clr) begin
      s1_valid  <= 1'b0;
      s1_bypass <= 1'b0;
      s1_noise  <= 1'b1;
      s1_data   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_bypass <= (branch == '0);
        s1_noise  <= filling;
        s1_data   <= in_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      out_valid <= 1'b0;
      out_noise <= 1'b1;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_noise <= s1_noise;
        out_data  <= s1_bypass ? s1_data : rd_data;
      end
    end
  end

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (clr)
    in_valid |=> ##1 out_valid);
  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (clr)
    !in_valid |=> ##1 !out_valid);
  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid && out_noise);
endmodule

// File: tb/byte_conv_interleaver_tb_top.sv
module byte_conv_interleaver_tb_top;
  localparam int NB = 12;
  localparam int ST = 17;
  localparam int FILL = (NB - 1) * ST * NB;

  logic clk = 1'b0;
  logic rst = 1'b1, flush = 1'b0, in_valid = 1'b0, in_sop = 1'b0;
  logic [7:0] in_data = '0;
  logic out_valid, out_noise;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  byte_conv_interleaver dut_i (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_noise(out_noise));

  typedef struct packed {
    logic       known;
    logic [3:0] br;
    logic [7:0] d;
    logic       noise;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  logic [7:0] hist [NB][1024];
  int visits [NB];
  int bptr = 0, cnt = 0, seed = 1;
  string phase = "R1";

  task automatic model_reset();
    for (int j = 0; j < NB; j++) visits[j] = 0;
    bptr = 0;
    cnt  = 0;
  endtask

  task automatic put(input logic [7:0] d, input logic s);
    exp_t e;
    int b, v;
    @(negedge clk);
    in_valid = 1'b1; in_sop = s; in_data = d;
    b = s ? 0 : bptr;
    v = visits[b];
    hist[b][v] = d;
    e.br    = 4'(b);
    e.noise = (cnt < FILL);
    e.known = (v >= b * ST);
    e.d     = e.known ? hist[b][v - b * ST] : 8'h00;
    q.push_back(e);
    visits[b] = v + 1;
    bptr = (b == NB - 1) ? 0 : b + 1;
    cnt++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0;
    end
  endtask

  task automatic packet(input int len, input bit mark, input bit gaps);
    for (int i = 0; i < len; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      put(i == 0 ? 8'h47 : 8'(seed >> 8), mark && i == 0);
      if (gaps && (seed % 5) == 3) idle(1 + seed % 3);
    end
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    if (!rst && out_valid) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R9 (%s): unexpected output got %0h expected none", phase, out_data);
      end else begin
        e = q.pop_front();
        if (out_noise !== e.noise) begin
          fails++;
          $display("FAIL R7 (%s): noise got %0b expected %0b", phase, out_noise, e.noise);
        end else if (e.known && out_data !== e.d) begin
          fails++;
          $display("FAIL %s (%s) branch %0d: data got %0h expected %0h",
                   e.br == 0 ? "R3" : "R2", phase, e.br, out_data, e.d);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 out_noise", 32'(out_noise), 1);
    phase = "R2";
    for (int p = 0; p < 6; p++) packet(204, 1, 0);
    phase = "R4";   // gapped input crosses the 2244-byte boundary (R7)
    for (int p = 0; p < 6; p++) packet(204, 1, 1);
    phase = "R6";   // unmarked packets rely on the wrap
    for (int p = 0; p < 2; p++) packet(204, 0, 0);
    phase = "R5";   // marker arrives with commutator at branch 4
    packet(100, 1, 0);
    packet(204, 1, 0);
    packet(204, 1, 1);
    idle(5);
    check("R9 drained", 32'(q.size()), 0);
    // R8: flush mid-stream
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    check("R8 out_valid", 32'(out_valid), 0);
    check("R8 out_noise", 32'(out_noise), 1);
    model_reset();
    phase = "R8";
    for (int p = 0; p < 12; p++) packet(204, 1, p % 3 == 1);
    idle(5);
    check("R9 final drain", 32'(q.size()), 0);
    check("R7 settled", 32'(out_noise), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule